// File: doc/BRIEF.md
# Multiplexed Bus Strobe Generator

This block produces the two timing strobes of a classic eight-bit controller's multiplexed external bus. One is the active-high address latch pulse. The other is the active-low code read strobe. A counter divides the oscillator clock into twelve-clock machine cycles. A small state register records, once per machine cycle, what kind of cycle is running, and a decoder turns the phase and that cycle kind into the strobe waveforms.

The sequencer also gives a per-cycle flag, `data_xfer`, for an external data move, and a flag, `code_read`, for a table read from code space. The level `ext_exec` says that code is fetched from outside. A narrow configuration write port holds a single latch-suppress bit at register address 0x8E. While that bit suppresses the latch pulse, the block raises `ale_weak` so that the pad can hold the line weakly high. The block drives no address, no data and no port multiplexing.

All three access inputs are captured on the clock edge that ends phase 11. They govern the whole machine cycle that follows. There are three cycle kinds:
- **CYC_PLAIN**: normal strobes.
- **CYC_XDATA**: an external data move.
- **CYC_MUTED**: the latch pulse is suppressed.

At every wrap the block selects the next kind:
- `data_xfer` gives CYC_XDATA.
- Otherwise, an effective suppress with no `code_read` gives CYC_MUTED.
- Otherwise the next kind is CYC_PLAIN.

Reset selects CYC_PLAIN.

Top module: `bus_strobe_gen`

## Requirements
- R1: Reset sets the phase to 0, clears the suppress bit and selects CYC_PLAIN with external execution not latched. After reset the phase counts 0,1,…,11 and then wraps to 0, one step per clock.
- R2: In a CYC_PLAIN cycle `ale` is high in phases 0,1 and 6,7 and low elsewhere. This gives two pulses per machine cycle, one every six clocks.
- R3: When `ext_exec` was captured high and the cycle is not CYC_XDATA, `psen_n` is low in phases 3,4,5 and 9,10,11 and high elsewhere. When `ext_exec` was captured low, `psen_n` stays high.
- R4: In a CYC_XDATA cycle `ale` is high only in phases 0,1, so the second pulse is dropped, and `psen_n` stays high for the whole cycle.
- R5: A configuration write with `cfg_we`=1 and `cfg_addr`=0x8E loads `cfg_wdata[0]` into the suppress bit. A write to any other address leaves the suppress bit unchanged.
- R6: When the suppress bit is 1, `ext_exec` is 0 and neither access flag is set, the next cycle is CYC_MUTED. In that cycle `ale` stays low and `ale_weak` stays high.
- R7: `code_read` or `data_xfer` overrides the suppress bit for that cycle, so the cycle is CYC_PLAIN or CYC_XDATA respectively.
- R8: When `ext_exec` is 1 the suppress bit has no effect.
- R9: The access inputs are taken only at the phase-11 edge. Changes at other phases do not alter the running cycle. `ale_weak` is low in every cycle that is not CYC_MUTED.
- R10: `ale` high and `psen_n` low never occur in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_exec | input | 1 | Code is fetched from external memory |
| data_xfer | input | 1 | Next machine cycle is an external data move |
| code_read | input | 1 | Next machine cycle is a code-space table read |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data (bit 0 used) |
| ale | output | 1 | Address latch pulse, active high |
| psen_n | output | 1 | Code read strobe, active low |
| ale_weak | output | 1 | Latch line held weakly high (pulse suppressed) |

## Verification
The assertions assume that the access flags are sampled only at the phase-11 edge and that the latched flags then hold through the cycle. The stimulus therefore changes `data_xfer`, `code_read` and `ext_exec` at the start of a cycle, except in one deliberate mid-cycle glitch on `data_xfer`. Every configuration write is a single-clock pulse placed early in a cycle, so that it lands before the wrap. All sixteen combinations of the three flags and the suppress bit are swept in two orders, so that each cycle kind follows a varied predecessor. Expected strobe levels for each phase are computed arithmetically from the previous cycle's settings.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
    typedef enum logic [1:0] {
        CYC_PLAIN = 2'd0,
        CYC_XDATA = 2'd1,
        CYC_MUTED = 2'd2
    } cyc_kind_t;
endpackage

// File: rtl/mc_phase.sv
module mc_phase #(
    parameter int CYC_CLKS = 12,
    localparam int PW = $clog2(CYC_CLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase,
    output logic          last
);
    localparam logic [PW-1:0] LAST_P = PW'(CYC_CLKS - 1);

    assign last = (phase == LAST_P);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    phase <= '0;
        else if (last) phase <= '0;
        else           phase <= phase + 1'b1;
    end

    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> phase == $past(phase) + 1'b1);
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> phase == '0);
endmodule

// File: rtl/ale_cfg.sv
module ale_cfg #(
    parameter logic [7:0] CFG_ADDR = 8'h8E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_addr,
    input  logic       cfg_bit,
    output logic       ale_off
);
    logic hit;
    assign hit = cfg_we && (cfg_addr == CFG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ale_off <= 1'b0;
        else if (hit) ale_off <= cfg_bit;
    end

    a_r5_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_addr == CFG_ADDR) |=> $stable(ale_off));
endmodule

// File: rtl/cyc_fsm.sv
module cyc_fsm
    import strobe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      last,
    input  logic      ext_exec,
    input  logic      data_xfer,
    input  logic      code_read,
    input  logic      ale_off,
    output cyc_kind_t kind,
    output logic      ext_q
);
    cyc_kind_t next_kind;
    logic      suppress;

    assign suppress = ale_off && !ext_exec;

    always_comb begin
        if (data_xfer)                   next_kind = CYC_XDATA;
        else if (suppress && !code_read) next_kind = CYC_MUTED;
        else                             next_kind = CYC_PLAIN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind  <= CYC_PLAIN;
            ext_q <= 1'b0;
        end else if (last) begin
            kind  <= next_kind;
            ext_q <= ext_exec;
        end
    end

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(kind) && $stable(ext_q));
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (last && data_xfer) |=> kind == CYC_XDATA);
    a_r8_ext_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (last && ext_exec && !data_xfer) |=> kind == CYC_PLAIN);
    a_r7_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (last && code_read && !data_xfer) |=> kind == CYC_PLAIN);
endmodule

// File: rtl/strobe_out.sv
module strobe_out
    import strobe_pkg::*;
#(
    parameter int CYC_CLKS   = 12,
    parameter int ALE_W      = 2,
    parameter int PSEN_START = 3,
    parameter int PSEN_W     = 3,
    localparam int PW = $clog2(CYC_CLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] phase,
    input  cyc_kind_t     kind,
    input  logic          ext_q,
    output logic          ale,
    output logic          psen_n,
    output logic          ale_weak
);
    localparam logic [PW-1:0] HALF_P = PW'(CYC_CLKS / 2);
    localparam logic [PW-1:0] ALE_P  = PW'(ALE_W);
    localparam logic [PW-1:0] PS0_P  = PW'(PSEN_START);
    localparam logic [PW-1:0] PS1_P  = PW'(PSEN_START + PSEN_W);

    logic [PW-1:0] hp;
    logic          first_half, ale_slot, psen_slot;

    assign first_half = phase < HALF_P;
    assign hp         = first_half ? phase : phase - HALF_P;
    assign ale_slot   = hp < ALE_P;
    assign psen_slot  = (hp >= PS0_P) && (hp < PS1_P);

    always_comb begin
        ale      = 1'b0;
        psen_n   = 1'b1;
        ale_weak = 1'b0;
        unique case (kind)
            CYC_PLAIN: begin
                ale    = ale_slot;
                psen_n = !(ext_q && psen_slot);
            end
            CYC_XDATA: begin
                ale    = ale_slot && first_half;
            end
            CYC_MUTED: begin
                ale_weak = 1'b1;
                psen_n   = !(ext_q && psen_slot);
            end
            default: begin
                ale = 1'b0;
            end
        endcase
    end

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale && !psen_n));
    a_r4_xdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_XDATA) |-> psen_n);
    a_r6_weak_low: assert property (@(posedge clk) disable iff (!rst_n)
        ale_weak |-> !ale);
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import strobe_pkg::*;
#(
    parameter int         CYC_CLKS   = 12,
    parameter int         ALE_W      = 2,
    parameter int         PSEN_START = 3,
    parameter int         PSEN_W     = 3,
    parameter logic [7:0] CFG_ADDR   = 8'h8E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_exec,
    input  logic       data_xfer,
    input  logic       code_read,
    input  logic       cfg_we,
    input  logic [7:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic       ale,
    output logic       psen_n,
    output logic       ale_weak
);
    localparam int PW = $clog2(CYC_CLKS);

    logic [PW-1:0] phase;
    logic          last, ale_off, ext_q;
    cyc_kind_t     kind;
    logic [6:0]    unused_wdata;

    assign unused_wdata = cfg_wdata[7:1];

    mc_phase #(.CYC_CLKS(CYC_CLKS)) u_phase (
        .clk(clk), .rst_n(rst_n), .phase(phase), .last(last));

    ale_cfg #(.CFG_ADDR(CFG_ADDR)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_bit(cfg_wdata[0]), .ale_off(ale_off));

    cyc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .last(last), .ext_exec(ext_exec),
        .data_xfer(data_xfer), .code_read(code_read), .ale_off(ale_off),
        .kind(kind), .ext_q(ext_q));

    strobe_out #(.CYC_CLKS(CYC_CLKS), .ALE_W(ALE_W),
                 .PSEN_START(PSEN_START), .PSEN_W(PSEN_W)) u_out (
        .clk(clk), .rst_n(rst_n), .phase(phase), .kind(kind), .ext_q(ext_q),
        .ale(ale), .psen_n(psen_n), .ale_weak(ale_weak));
endmodule

// File: tb/sim_bus_strobe_gen.sv
`timescale 1ns/1ps
module sim_bus_strobe_gen;
    logic clk = 0, rst_n = 0;
    logic ext_exec = 0, data_xfer = 0, code_read = 0, cfg_we = 0;
    logic [7:0] cfg_addr = 0, cfg_wdata = 0;
    logic ale, psen_n, ale_weak;
    int checks = 0, failures = 0;
    bit done = 0;
    logic pe = 0, pd = 0, px = 0, pc = 0;

    always #5 clk = ~clk;

    bus_strobe_gen u0 (.clk(clk), .rst_n(rst_n), .ext_exec(ext_exec),
        .data_xfer(data_xfer), .code_read(code_read), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ale(ale),
        .psen_n(psen_n), .ale_weak(ale_weak));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit muted_f(input logic e, d, x, c);
        return d && !e && !x && !c;
    endfunction
    function automatic logic exp_ale(input logic e, d, x, c, input int ph);
        if (x) return ph < 2;
        if (muted_f(e, d, x, c)) return 1'b0;
        return (ph % 6) < 2;
    endfunction
    function automatic logic exp_psen(input logic e, d, x, c, input int ph);
        return !(e && !x && (ph % 6) >= 3);
    endfunction
    function automatic string tag_of(input logic e, d, x, c);
        if (x) return "R4";
        if (muted_f(e, d, x, c)) return "R6";
        if (d && e) return "R8";
        if (d && c) return "R7";
        if (e) return "R3";
        return "R2";
    endfunction

    // Called at the negedge of phase 0; observes the running cycle, applies new settings.
    task automatic do_cycle(input logic ne, nd, nx, nc, input logic [7:0] waddr, input bit glitch);
        int bad = 0, weak_bad = 0, pulses = 0, exp_pulses = 0, ovl = 0;
        logic prev_ale = 0;
        string t = tag_of(pe, pd, px, pc);
        ext_exec = ne; data_xfer = nx; code_read = nc;
        cfg_we = 1; cfg_addr = waddr; cfg_wdata = {7'b0, nd};
        for (int ph = 0; ph < 12; ph++) begin
            if (ale !== exp_ale(pe, pd, px, pc, ph) || psen_n !== exp_psen(pe, pd, px, pc, ph)) bad++;
            if (ale_weak !== muted_f(pe, pd, px, pc)) weak_bad++;
            if (ale && !psen_n) ovl++;
            if (ale && !prev_ale) pulses++;
            if (exp_ale(pe, pd, px, pc, ph) && (ph == 0 || !exp_ale(pe, pd, px, pc, ph - 1))) exp_pulses++;
            prev_ale = ale;
            @(posedge clk); @(negedge clk);
            if (ph == 0) cfg_we = 0;
            if (glitch && ph == 4) data_xfer = ~nx;
            if (glitch && ph == 7) data_xfer = nx;
        end
        chk(bad == 0, {t, " strobe waveform"}, bad, 0);
        chk(pulses == exp_pulses, {t, " ale pulse count"}, pulses, exp_pulses);
        chk(weak_bad == 0, muted_f(pe, pd, px, pc) ? "R6 ale_weak high" : "R9 ale_weak low", weak_bad, 0);
        chk(ovl == 0, "R10 no overlap", ovl, 0);
        pe = ne; px = nx; pc = nc;
        if (waddr == 8'h8E) pd = nd;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ale === 1'b1 && psen_n === 1'b1 && ale_weak === 1'b0, "R1 reset outputs", {ale, psen_n, ale_weak}, 3'b110);
        rst_n = 1;
        // phase 0 now; first cycle after reset is plain with no code strobe
        do_cycle(0, 0, 0, 0, 8'h8E, 0);
        for (int i = 0; i < 16; i++)  do_cycle(i[3], i[2], i[1], i[0], 8'h8E, 0);
        for (int i = 15; i >= 0; i--) do_cycle(i[3], i[2], i[1], i[0], 8'h8E, 0);
        do_cycle(0, 0, 0, 0, 8'h8E, 0);
        // R5: write suppress to a different address, must be ignored
        do_cycle(0, 1, 0, 0, 8'h8F, 0);
        chk(ale_weak === 1'b0, "R5 other address ignored", ale_weak, 0);
        do_cycle(0, 0, 0, 0, 8'h8E, 0);
        // R9: mid-cycle data_xfer glitch has no effect
        do_cycle(1, 0, 0, 0, 8'h8E, 1);
        do_cycle(1, 0, 0, 0, 8'h8E, 1);
        do_cycle(0, 0, 0, 0, 8'h8E, 0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule